// File: doc/BRIEF.md
# Slave Address Recognizer for a Two-Wire Serial Bus

This block sits behind the bit-level receiver of a two-wire serial bus slave. After each START or repeated START it looks at the received address bytes. It decides whether this slave is being addressed and in which direction. For every address byte it gives an acknowledge or no-acknowledge decision, which the pin driver turns into SDA held LOW or SDA released during the ninth clock pulse. It recognizes either a 7-bit own address or a 10-bit own address, as selected by a mode input.

In 10-bit mode the match takes two stages. A header byte `11110` followed by the two high address bits and a write bit is acknowledged. The next byte is then compared in full with the low eight address bits. A slave that was fully selected this way stays selected across a repeated START. A later header with the read bit then makes it a slave transmitter without resending the low byte. The own address and the mode are sampled only when a START or repeated START is seen.

Top module: `slave_addr_recognizer`

## Requirements
- R1: In 7-bit mode, the first byte after a START or repeated START is acknowledged when bits 7:1 equal `own_addr[6:0]`. `addressed` then goes to 1 and `slave_tx` takes bit 0 of the byte (1 = master reads). A mismatch is not acknowledged and clears `addressed`.
- R2: In 7-bit mode, first bytes whose bits 7:4 are `0000` or `1111` are never acknowledged, even when they equal the own address. This covers the START byte `00000001`, the bus-compatibility address `0000001x`, and 10-bit headers.
- R3: In 10-bit mode, a first byte equal to `11110` & `own_addr[9:8]` & `0` is acknowledged with `addressed` still 0. A following byte equal to `own_addr[7:0]` is then acknowledged, and `addressed`=1 with `slave_tx`=0. A header carrying other high bits is not acknowledged.
- R4: In 10-bit mode, a second byte that differs from `own_addr[7:0]` in any bit is not acknowledged and leaves `addressed` at 0.
- R5: After a full 10-bit match and a repeated START, a first byte `11110` & `own_addr[9:8]` & `1` is acknowledged and sets `addressed`=1 and `slave_tx`=1.
- R6: A 10-bit read header is not acknowledged when no full 10-bit match has happened since the last STOP or START.
- R7: `addressed` stays set through a repeated START until the next address byte decides. A STOP clears `addressed`, `slave_tx` and the remembered 10-bit selection. An address byte after a repeated START that does not select the slave clears `addressed`.
- R8: `own_addr` and `ten_bit_mode` are sampled only on START or repeated START. Changes between those events do not affect matching until the next START or repeated START.
- R9: `ack_vld` pulses for exactly one cycle, one clock after `byte_vld`, and only for address bytes. Data bytes after the decision, and bytes received before any START, give no pulse. `ack` is 1 only together with `ack_vld`.
- R10: When a START, repeated START or STOP comes in the same cycle as `byte_vld`, the bus condition takes effect and that byte is discarded without a decision.
- R11: After reset, `ack_vld`, `ack`, `addressed` and `slave_tx` are 0, and incoming bytes are ignored until a START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_det | input | 1 | One-cycle strobe: START seen |
| rstart_det | input | 1 | One-cycle strobe: repeated START seen |
| stop_det | input | 1 | One-cycle strobe: STOP seen |
| byte_vld | input | 1 | One-cycle strobe: `byte_data` holds a received byte |
| byte_data | input | 8 | Received byte, first bit on the wire in bit 7 |
| own_addr | input | 10 | Own address; bits 6:0 are used in 7-bit mode |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| ack_vld | output | 1 | Decision pulse for an address byte |
| ack | output | 1 | 1 = drive SDA LOW on the ninth clock pulse |
| addressed | output | 1 | This slave is selected |
| slave_tx | output | 1 | 1 = slave transmits (master reads) |

## Verification
A received byte and a bus condition (START, repeated START or STOP) can both arrive in the same cycle. The bench raises `byte_vld` in the same cycle as a STOP and, separately, in the same cycle as a START. It then confirms that no decision pulse follows and that the state matches what the condition alone produces. In the START case, the next byte must still be judged as the address. A behavioural reference model follows every cycle and flags any difference on the four outputs. Directed checks cover the reserved codes and the repeated-START read path.

// File: rtl/slave_addr_recognizer.sv
module slave_addr_recognizer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_det,
  input  logic       rstart_det,
  input  logic       stop_det,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  input  logic [9:0] own_addr,
  input  logic       ten_bit_mode,
  output logic       ack_vld,
  output logic       ack,
  output logic       addressed,
  output logic       slave_tx
);

  typedef enum logic [1:0] {PH_IDLE, PH_FIRST, PH_SECOND, PH_DONE} phase_t;

  phase_t     ph, nxt_ph;
  logic [9:0] own_q;
  logic       mode_q;
  logic       sel10_q, nxt_sel;
  logic       dec_ack, nxt_addr, nxt_tx;

  wire [6:0] hi7   = byte_data[7:1];
  wire       rdbit = byte_data[0];
  wire       rsv7  = (hi7[6:3] == 4'b0000) || (hi7[6:3] == 4'b1111);
  wire       hit7  = !rsv7 && (hi7 == own_q[6:0]);
  wire       hdr10 = (byte_data[7:3] == 5'b11110) && (byte_data[2:1] == own_q[9:8]);
  wire       lo10  = (byte_data == own_q[7:0]);
  wire       cond  = start_det | rstart_det | stop_det;
  wire       take  = byte_vld && !cond && (ph == PH_FIRST || ph == PH_SECOND);

  always_comb begin
    nxt_ph   = ph;
    nxt_sel  = sel10_q;
    nxt_addr = addressed;
    nxt_tx   = slave_tx;
    dec_ack  = 1'b0;
    if (ph == PH_FIRST && !mode_q) begin
      dec_ack  = hit7;
      nxt_addr = hit7;
      nxt_tx   = hit7 & rdbit;
      nxt_sel  = 1'b0;
      nxt_ph   = PH_DONE;
    end else if (ph == PH_FIRST) begin
      if (hdr10 && !rdbit) begin
        dec_ack  = 1'b1;
        nxt_addr = 1'b0;
        nxt_tx   = 1'b0;
        nxt_sel  = 1'b0;
        nxt_ph   = PH_SECOND;
      end else if (hdr10 && sel10_q) begin
        dec_ack  = 1'b1;
        nxt_addr = 1'b1;
        nxt_tx   = 1'b1;
        nxt_ph   = PH_DONE;
      end else begin
        nxt_addr = 1'b0;
        nxt_tx   = 1'b0;
        nxt_sel  = 1'b0;
        nxt_ph   = PH_DONE;
      end
    end else if (ph == PH_SECOND) begin
      dec_ack  = lo10;
      nxt_addr = lo10;
      nxt_tx   = 1'b0;
      nxt_sel  = lo10;
      nxt_ph   = PH_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      own_q     <= '0;
      mode_q    <= 1'b0;
      sel10_q   <= 1'b0;
      addressed <= 1'b0;
      slave_tx  <= 1'b0;
      ack_vld   <= 1'b0;
      ack       <= 1'b0;
    end else begin
      ack_vld <= take;
      ack     <= take & dec_ack;
      if (stop_det) begin
        ph        <= PH_IDLE;
        sel10_q   <= 1'b0;
        addressed <= 1'b0;
        slave_tx  <= 1'b0;
      end else if (start_det) begin
        ph        <= PH_FIRST;
        own_q     <= own_addr;
        mode_q    <= ten_bit_mode;
        sel10_q   <= 1'b0;
        addressed <= 1'b0;
        slave_tx  <= 1'b0;
      end else if (rstart_det) begin
        ph     <= PH_FIRST;
        own_q  <= own_addr;
        mode_q <= ten_bit_mode;
      end else if (take) begin
        ph        <= nxt_ph;
        sel10_q   <= nxt_sel;
        addressed <= nxt_addr;
        slave_tx  <= nxt_tx;
      end
    end
  end

endmodule

module slave_addr_recognizer_chk (
  input logic clk,
  input logic rst_n,
  input logic start_det,
  input logic rstart_det,
  input logic stop_det,
  input logic byte_vld,
  input logic ack_vld,
  input logic ack,
  input logic addressed,
  input logic slave_tx
);
  AST_DECISION_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld == 1'b0 |=> !ack_vld);                                    // R9
  AST_ACK_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ack_vld);                                                  // R9
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |=> !ack_vld);                                             // R9
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !addressed && !slave_tx);                             // R7
  AST_TX_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    slave_tx |-> addressed);                                           // R5
  AST_COND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || rstart_det || stop_det) |=> !ack_vld);               // R10
  AST_SELECT_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed) |-> ack_vld && ack);                              // R1
endmodule

bind slave_addr_recognizer slave_addr_recognizer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_det(start_det), .rstart_det(rstart_det),
  .stop_det(stop_det), .byte_vld(byte_vld), .ack_vld(ack_vld), .ack(ack),
  .addressed(addressed), .slave_tx(slave_tx)
);

// File: tb/test_slave_addr_recognizer.sv
module test_slave_addr_recognizer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_det = 1'b0, rstart_det = 1'b0, stop_det = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [9:0] own_addr = 10'h000;
  logic       ten_bit_mode = 1'b0;
  logic       ack_vld, ack, addressed, slave_tx;

  int    checks = 0, fails = 0, cycles = 0;
  string cur_req = "R11";

  slave_addr_recognizer i_slave_addr_recognizer (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .rstart_det(rstart_det),
    .stop_det(stop_det), .byte_vld(byte_vld), .byte_data(byte_data),
    .own_addr(own_addr), .ten_bit_mode(ten_bit_mode), .ack_vld(ack_vld),
    .ack(ack), .addressed(addressed), .slave_tx(slave_tx));

  always #5 clk = ~clk;

  // behavioural reference: phase 0 idle, 1 first byte, 2 second byte, 3 decided
  int m_phase = 0;
  int m_own = 0;
  bit m_ten = 0, m_sel = 0, m_addr = 0, m_tx = 0, m_av = 0, m_ack = 0;

  always @(posedge clk) begin
    int b, top;
    if (!rst_n) begin
      m_phase = 0; m_own = 0; m_ten = 0; m_sel = 0;
      m_addr = 0; m_tx = 0; m_av = 0; m_ack = 0;
    end else begin
      m_av = 0; m_ack = 0;
      b = byte_data;
      top = b / 2;
      if (stop_det) begin
        m_phase = 0; m_sel = 0; m_addr = 0; m_tx = 0;
      end else if (start_det) begin
        m_phase = 1; m_sel = 0; m_addr = 0; m_tx = 0;
        m_own = own_addr; m_ten = ten_bit_mode;
      end else if (rstart_det) begin
        m_phase = 1; m_own = own_addr; m_ten = ten_bit_mode;
      end else if (byte_vld && (m_phase == 1 || m_phase == 2)) begin
        m_av = 1;
        if (m_phase == 2) begin
          m_ack = (b == m_own % 256);
          m_addr = m_ack; m_tx = 0; m_sel = m_ack; m_phase = 3;
        end else if (!m_ten) begin
          m_ack = (top >= 8 && top < 120 && top == m_own % 128);
          m_addr = m_ack; m_tx = m_ack && (b % 2 == 1); m_sel = 0; m_phase = 3;
        end else if (b == 240 + 2 * (m_own / 256)) begin
          m_ack = 1; m_addr = 0; m_tx = 0; m_sel = 0; m_phase = 2;
        end else if (b == 241 + 2 * (m_own / 256) && m_sel) begin
          m_ack = 1; m_addr = 1; m_tx = 1; m_phase = 3;
        end else begin
          m_addr = 0; m_tx = 0; m_sel = 0; m_phase = 3;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if ({ack_vld, ack, addressed, slave_tx} !== {m_av, m_ack, m_addr, m_tx}) begin
        fails++;
        $display("FAIL %s model cycle %0d: got %b%b%b%b expected %b%b%b%b", cur_req, cycles,
                 ack_vld, ack, addressed, slave_tx, m_av, m_ack, m_addr, m_tx);
      end
    end
    if (cycles >= 100000) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic ev, input logic ea,
                     input logic ead, input logic etx);
    checks++;
    if ({ack_vld, ack, addressed, slave_tx} !== {ev, ea, ead, etx}) begin
      fails++;
      $display("FAIL %s: got vld=%b ack=%b addr=%b tx=%b expected vld=%b ack=%b addr=%b tx=%b",
               req, ack_vld, ack, addressed, slave_tx, ev, ea, ead, etx);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_vld = 1'b1; byte_data = b;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    start_det = (which == 0); rstart_det = (which == 1); stop_det = (which == 2);
    @(negedge clk);
    start_det = 1'b0; rstart_det = 1'b0; stop_det = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", 0, 0, 0, 0);
    cur_req = "R9";
    send(8'hA0); chk("R9", 0, 0, 0, 0);

    cur_req = "R1"; own_addr = 10'h050; ten_bit_mode = 1'b0;
    pulse(0); send(8'hA0); chk("R1", 1, 1, 1, 0);
    cur_req = "R9";
    send(8'h55); chk("R9", 0, 0, 1, 0);
    cur_req = "R7";
    pulse(1); chk("R7", 0, 0, 1, 0);
    cur_req = "R1";
    send(8'hA1); chk("R1", 1, 1, 1, 1);
    cur_req = "R7";
    pulse(1); send(8'h42); chk("R7", 1, 0, 0, 0);
    pulse(2);

    cur_req = "R2";
    own_addr = 10'h000; pulse(0); send(8'h01); chk("R2", 1, 0, 0, 0); pulse(2);
    own_addr = 10'h001; pulse(0); send(8'h02); chk("R2", 1, 0, 0, 0); pulse(2);
    own_addr = 10'h078; pulse(0); send(8'hF0); chk("R2", 1, 0, 0, 0); pulse(2);
    own_addr = 10'h07F; pulse(0); send(8'hFF); chk("R2", 1, 0, 0, 0); pulse(2);

    cur_req = "R8";
    own_addr = 10'h050; pulse(0); own_addr = 10'h033; ten_bit_mode = 1'b1;
    send(8'hA0); chk("R8", 1, 1, 1, 0); pulse(2);
    ten_bit_mode = 1'b0;
    pulse(0); send(8'hA0); chk("R8", 1, 0, 0, 0); pulse(2);

    cur_req = "R3"; own_addr = 10'h2A5; ten_bit_mode = 1'b1;
    pulse(0); send(8'hF4); chk("R3", 1, 1, 0, 0);
    send(8'hA5); chk("R3", 1, 1, 1, 0);
    cur_req = "R7";
    pulse(1); chk("R7", 0, 0, 1, 0);
    cur_req = "R5";
    send(8'hF5); chk("R5", 1, 1, 1, 1);
    cur_req = "R7";
    pulse(2); chk("R7", 0, 0, 0, 0);

    cur_req = "R6";
    pulse(0); send(8'hF5); chk("R6", 1, 0, 0, 0); pulse(2);
    cur_req = "R4";
    pulse(0); send(8'hF4); send(8'hA4); chk("R4", 1, 0, 0, 0);
    cur_req = "R6";
    pulse(1); send(8'hF5); chk("R6", 1, 0, 0, 0); pulse(2);
    cur_req = "R3";
    pulse(0); send(8'hF2); chk("R3", 1, 0, 0, 0); pulse(2);

    cur_req = "R10"; own_addr = 10'h050; ten_bit_mode = 1'b0;
    pulse(0); send(8'hA0);
    @(negedge clk); stop_det = 1'b1; byte_vld = 1'b1; byte_data = 8'hA0;
    @(negedge clk); stop_det = 1'b0; byte_vld = 1'b0;
    chk("R10", 0, 0, 0, 0);
    @(negedge clk); start_det = 1'b1; byte_vld = 1'b1; byte_data = 8'hA1;
    @(negedge clk); start_det = 1'b0; byte_vld = 1'b0;
    chk("R10", 0, 0, 0, 0);
    send(8'hA1); chk("R10", 1, 1, 1, 1);
    pulse(2);
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule